// File: doc/BRIEF.md
# SRAM Sleep-Pin Power-Down Sequencer

This block sits between a memory controller's command stream and a pipelined synchronous SRAM that has no bus turnaround. It owns the SRAM's asynchronous, active-high sleep pin. Commands arrive on a valid/ready handshake. Accepted commands are forwarded to the memory in the same cycle as an enable and a write strobe. A two-stage tracker follows each accepted command until its data phase is over. The tracker also flags the cycle in which read data is on the bus.

When the controller asks for sleep, the block stops accepting commands and waits until the pipeline is empty. It then raises the sleep pin and holds it for at least a minimum window, and for as long as sleep stays requested. When the request drops, the pin falls and a recovery window follows. During that window reads and idle cycles pass, but writes stall with valid held. A request that is shorter than the drain still runs one complete drain, sleep and recovery sequence, so the pin never produces a short pulse. A status output reports that the memory is fully asleep. Once it is high, the controller may drop the request at any time.

Top module: `sram_sleep_seq`

## Requirements
- R1: While reset is asserted and right after it, the sleep pin, asleep status and read-data-valid outputs are low, and the block is in its active state.
- R2: In the active state with no sleep request, `cmd_ready` is high. An accepted command drives `mem_en` high in the same cycle, with `mem_we` equal to `cmd_write` (1 = write, 0 = read). With no valid command, `mem_en` is low.
- R3: `rd_valid` is high exactly 2 cycles after each accepted read and at no other time. An accepted write never produces it.
- R4: From the first cycle in which `sleep_req` is seen high in the active state, and through the drain and sleep phases, `cmd_ready` and `mem_en` are low.
- R5: The sleep pin first goes high in cycle max(n+1, L+3)+1, where n is the cycle in which the request was first seen and L is the cycle of the last accepted command. No command is accepted in the 2 cycles before the pin rises.
- R6: Once raised, the sleep pin stays high for at least WIN_CYC (default 2) cycles. `asleep` rises in cycle WIN_CYC-1 after the pin rises.
- R7: If `sleep_req` is low in a cycle where `asleep` is high, the sleep pin and `asleep` are both low in the next cycle. `asleep` is never high while the pin is low.
- R8: The recovery window lasts WIN_CYC cycles after the pin falls. In it, reads are accepted and writes see `cmd_ready` low, so `mem_we` stays low. A held write is accepted in the first cycle after the window.
- R9: A sleep request that is high for a single cycle still produces a full drain, a sleep of WIN_CYC cycles and a recovery.
- R10: `rd_valid` is never high while the sleep pin is high.
- R11: `mem_en` is never high while the sleep pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Controller asks for memory sleep |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | Offered command is a write (1) or read (0) |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| mem_en | output | 1 | Command issued to the memory this cycle |
| mem_we | output | 1 | Issued command is a write |
| mem_zz | output | 1 | Memory sleep pin, active high |
| rd_valid | output | 1 | Read data is on the memory bus this cycle |
| asleep | output | 1 | Memory asleep and minimum hold met |

## Verification
Handshake results (`cmd_ready`, `mem_en`, `mem_we`) are due in the same cycle as the inputs that cause them. `rd_valid` is due 2 cycles after the accepted read. The sleep pin is due in the cycle R5 gives. After the request drops, the pin and `asleep` fall 1 cycle later, and the recovery window ends WIN_CYC cycles after the pin falls. Inputs are changed just after the rising edge and every output is read at the falling edge of the same cycle. A scoreboard queue holds the cycle number due for each read, and every `rd_valid` pops the oldest entry and compares it with the current cycle. The directed sequences compare each cycle's outputs against the cycle numbers counted from the start of the request.

// File: rtl/sslp_pkg.sv
package sslp_pkg;

  typedef enum logic [1:0] {
    SS_ACTIVE  = 2'd0,
    SS_DRAIN   = 2'd1,
    SS_SLEEP   = 2'd2,
    SS_RECOVER = 2'd3
  } sslp_state_e;

  // Handshake rule: which offered commands may pass in a given phase.
  function automatic logic ready_rule(sslp_state_e st, logic sreq, logic is_wr);
    case (st)
      SS_ACTIVE:  return !sreq;
      SS_RECOVER: return !is_wr;
      default:    return 1'b0;
    endcase
  endfunction

  // Phase sequencing: drain before sleep, hold, then recover.
  function automatic sslp_state_e next_phase(sslp_state_e st, logic sreq,
                                             logic pipe_empty, logic tmr_done);
    case (st)
      SS_ACTIVE:  return sreq ? SS_DRAIN : SS_ACTIVE;
      SS_DRAIN:   return pipe_empty ? SS_SLEEP : SS_DRAIN;
      SS_SLEEP:   return (tmr_done && !sreq) ? SS_RECOVER : SS_SLEEP;
      default:    return tmr_done ? SS_ACTIVE : SS_RECOVER;
    endcase
  endfunction

endpackage

// File: rtl/sslp_gate.sv
module sslp_gate
  import sslp_pkg::*;
(
  input  sslp_state_e state,
  input  logic        sleep_req,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  output logic        cmd_ready,
  output logic        mem_en,
  output logic        mem_we
);

  always_comb begin
    cmd_ready = ready_rule(state, sleep_req, cmd_write);
    mem_en    = cmd_valid && cmd_ready;
    mem_we    = mem_en && cmd_write;
  end

endmodule

// File: rtl/sslp_pipe_track.sv
module sslp_pipe_track #(
  parameter int PIPE_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic issue_rd,
  output logic pipe_empty,
  output logic rd_valid
);

  logic [PIPE_DEPTH-1:0] occ_q;
  logic [PIPE_DEPTH-1:0] rd_q;

  generate
    if (PIPE_DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          occ_q <= '0;
          rd_q  <= '0;
        end else begin
          occ_q <= issue;
          rd_q  <= issue_rd;
        end
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          occ_q <= '0;
          rd_q  <= '0;
        end else begin
          occ_q <= {occ_q[PIPE_DEPTH-2:0], issue};
          rd_q  <= {rd_q[PIPE_DEPTH-2:0], issue_rd};
        end
      end
    end
  endgenerate

  assign pipe_empty = ~|occ_q;
  assign rd_valid   = rd_q[PIPE_DEPTH-1];

endmodule

// File: rtl/sslp_fsm.sv
module sslp_fsm
  import sslp_pkg::*;
#(
  parameter int WIN_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_req,
  input  logic        pipe_empty,
  output sslp_state_e state,
  output logic        tmr_done,
  output logic        sleep_pin
);

  localparam int TW = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [TW-1:0] RELOAD = TW'(WIN_CYC - 1);

  sslp_state_e state_nx;
  logic [TW-1:0] tmr_q;

  assign tmr_done = (tmr_q == '0);
  assign state_nx = next_phase(state, sleep_req, pipe_empty, tmr_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SS_ACTIVE;
      tmr_q     <= '0;
      sleep_pin <= 1'b0;
    end else begin
      state     <= state_nx;
      sleep_pin <= (state_nx == SS_SLEEP);
      if (state_nx != state) tmr_q <= RELOAD;
      else if (!tmr_done)    tmr_q <= tmr_q - 1'b1;
    end
  end

endmodule

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq
  import sslp_pkg::*;
#(
  parameter int WIN_CYC    = 2,
  parameter int PIPE_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic cmd_valid,
  input  logic cmd_write,
  output logic cmd_ready,
  output logic mem_en,
  output logic mem_we,
  output logic mem_zz,
  output logic rd_valid,
  output logic asleep
);

  sslp_state_e state;
  logic pipe_empty;
  logic tmr_done;
  logic in_drain, in_sleep, in_recover;

  sslp_gate u_gate (
    .state     (state),
    .sleep_req (sleep_req),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_ready (cmd_ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
  );

  sslp_pipe_track #(.PIPE_DEPTH(PIPE_DEPTH)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (mem_en),
    .issue_rd   (mem_en && !mem_we),
    .pipe_empty (pipe_empty),
    .rd_valid   (rd_valid)
  );

  sslp_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .pipe_empty (pipe_empty),
    .state      (state),
    .tmr_done   (tmr_done),
    .sleep_pin  (mem_zz)
  );

  assign in_drain   = (state == SS_DRAIN);
  assign in_sleep   = (state == SS_SLEEP);
  assign in_recover = (state == SS_RECOVER);
  assign asleep     = in_sleep && tmr_done;

endmodule

// File: rtl/sram_sleep_seq_chk.sv
module sram_sleep_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic mem_en,
  input logic mem_we,
  input logic mem_zz,
  input logic rd_valid,
  input logic asleep,
  input logic in_drain,
  input logic in_sleep,
  input logic in_recover
);

  a_r4_ready_low_drain_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drain || in_sleep) |-> !cmd_ready);

  a_r5_pipe_quiet_before_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_zz) |-> (!$past(mem_en) && !$past(mem_en, 2)));

  a_r3_read_return: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_en && !mem_we, 2));

  a_r6_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_zz) |-> $past(mem_zz, 2));

  a_r7_asleep_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> mem_zz);

  a_r8_recover_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_recover |-> !mem_we);

  a_r10_no_rdata_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    mem_zz |-> !rd_valid);

  a_r11_no_issue_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    mem_zz |-> !mem_en);

endmodule

bind sram_sleep_seq sram_sleep_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_zz     (mem_zz),
  .rd_valid   (rd_valid),
  .asleep     (asleep),
  .in_drain   (in_drain),
  .in_sleep   (in_sleep),
  .in_recover (in_recover)
);

// File: tb/sram_sleep_seq_tb.sv
module sram_sleep_seq_tb;

  localparam int PIPE = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sleep_req, cmd_valid, cmd_write;
  logic cmd_ready, mem_en, mem_we, mem_zz, rd_valid, asleep;

  sram_sleep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_ready(cmd_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_zz(mem_zz),
    .rd_valid(rd_valid), .asleep(asleep)
  );

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int due_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic s);
    @(posedge clk);
    #1;
    cmd_valid = v;
    cmd_write = w;
    sleep_req = s;
    @(negedge clk);
  endtask

  // Scoreboard monitor: reads are due PIPE cycles after acceptance.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid && cmd_ready && !cmd_write) due_q.push_back(cyc + PIPE);
      if (rd_valid) begin
        if (due_q.size() == 0) check("R3 read return without read", 1, 0);
        else check("R3 read return cycle", cyc, due_q.pop_front());
      end
      if (mem_zz) begin
        check("R11 issue while pin high", int'(mem_en), 0);
        check("R10 read data while pin high", int'(rd_valid), 0);
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, s, m, p;
    rst_n = 1'b0; sleep_req = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pin in reset", int'(mem_zz), 0);
    check("R1 asleep in reset", int'(asleep), 0);
    check("R1 rd_valid in reset", int'(rd_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2: active passthrough
    step(1, 0, 0);
    check("R1 ready after reset", int'(cmd_ready), 1);
    check("R2 read issued", int'(mem_en), 1);
    check("R2 read strobe", int'(mem_we), 0);
    step(1, 1, 0);
    check("R2 write ready", int'(cmd_ready), 1);
    check("R2 write strobe", int'(mem_we), 1);
    step(1, 0, 0);
    step(0, 0, 0);
    check("R2 idle no issue", int'(mem_en), 0);

    // Sleep with a read in flight (accepted in cycle n-1)
    step(1, 0, 0);
    step(1, 1, 1);
    n = cyc;
    check("R4 ready low on request", int'(cmd_ready), 0);
    check("R4 no issue on request", int'(mem_en), 0);
    for (int i = 1; i <= 3; i++) begin
      step(1, 1, 1);
      check("R5 pin timing", int'(mem_zz), (cyc >= n + 3) ? 1 : 0);
      check("R4 ready low draining", int'(cmd_ready), 0);
    end
    s = cyc;
    check("R6 asleep not yet", int'(asleep), 0);
    for (int i = 1; i <= 3; i++) begin
      step(0, 0, 1);
      check("R6 asleep after hold", int'(asleep), 1);
      check("R6 pin held", int'(mem_zz), 1);
    end
    step(1, 1, 0);
    m = cyc;
    check("R7 pin still high", int'(mem_zz), 1);
    check("R4 ready low sleeping", int'(cmd_ready), 0);
    step(1, 1, 0);
    check("R7 pin falls", int'(mem_zz), 0);
    check("R7 asleep falls", int'(asleep), 0);
    check("R8 write stalled 1", int'(cmd_ready), 0);
    step(1, 1, 0);
    check("R8 write stalled 2", int'(cmd_ready), 0);
    check("R8 no write strobe", int'(mem_we), 0);
    step(1, 1, 0);
    check("R8 write after window", int'(mem_we), 1);
    check("R8 window length", cyc - m, 3);
    if (s != n + 3) check("R5 entry cycle", s, n + 3);
    repeat (3) step(0, 0, 0);

    // R9: one-cycle request, empty pipeline
    step(0, 0, 1);
    p = cyc;
    step(0, 0, 0);
    check("R9 pin low in drain", int'(mem_zz), 0);
    step(0, 0, 0);
    check("R9 pin rises", int'(mem_zz), 1);
    check("R6 asleep waits", int'(asleep), 0);
    step(0, 0, 0);
    check("R6 pin held short req", int'(mem_zz), 1);
    check("R6 asleep short req", int'(asleep), 1);
    step(1, 0, 0);
    check("R9 pin falls", int'(mem_zz), 0);
    check("R8 read passes recover", int'(mem_en), 1);
    step(1, 1, 0);
    check("R8 write stalled recover", int'(cmd_ready), 0);
    step(1, 1, 0);
    check("R8 write back in active", int'(cmd_ready), 1);
    check("R9 sequence length", cyc - p, 6);
    repeat (4) step(0, 0, 0);
    check("R3 all reads returned", due_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule